// File: doc/BRIEF.md
# Synthetic-Sample ADC Register File

This block is the register window of one analog-to-digital converter channel group, reached over a plain 32-bit word bus with separate read and write strobes. It stores the control, status, sample-time, threshold, sequence and injected-channel words that software expects to find. It contains no converter. A read of the regular data word, made while the converter is switched on and a software start is pending, returns a synthetic sample. That sample comes from an accumulator that advances by a fixed step on each such read, is cut to the selected resolution, and can be returned left-shifted.

The intended use is system bring-up and driver development, where firmware must see a live, changing data word without a real analog front end. Read data is registered: the value appears on `rd_data` in the cycle after the read strobe and holds until the next read. Side effects of a read (consuming the start request, advancing the accumulator) take place on the clock edge that samples the read strobe.

Top module: `adc_rf_synth`

## Requirements
- R1: After reset every word reads zero, except the high threshold word at 0x24, which reads 0x0000_0FFF.
- R2: A write to the status word at 0x00 replaces it with its current value ANDed with the low 6 bits of the write data. Bits 31:6 always read zero, and no flag is ever set by this block, so the word reads zero.
- R3: The words at 0x04 (control A), 0x0C and 0x10 (sample times), 0x24 and 0x28 (high and low thresholds), 0x2C to 0x34 (sequence) and 0x38 (injected sequence) read back exactly the last value written.
- R4: Control B at 0x08 stores all 32 written bits, but a read returns only bits 27:0, with bits 31:28 zero. The stored upper bits still act, including the start request at bit 30.
- R5: The four injected offset words at 0x14, 0x18, 0x1C and 0x20 keep only bits 11:0 of a write, and the other bits read zero.
- R6: A read of injected data word n (0x3C + 4n, n = 0..3) returns the stored data n minus offset n, modulo 2^32.
- R7: A data read at 0x4C while control B bit 0 (enable) and bit 30 (start) are both 1 is armed. It clears bit 30, sets the stored sample to (stored + 7) masked to the resolution, and returns that sample in the next cycle.
- R8: The resolution code is control A bits 25:24: 0 selects a 0xFFF mask, 1 selects 0x3FF, 2 selects 0xFF and 3 selects 0x3F. The masked value is the one stored for the next step.
- R9: When control B bit 11 is 1, an armed data read returns (sample << 1) & 0xFFF0. When bit 11 is 0, it returns the sample unchanged.
- R10: A data read made while enable or start is 0 returns zero and changes neither the sample nor control B.
- R11: Offsets that are not word-aligned or lie above 0x4C read zero, and writes to them change no register.
- R12: `rd_data` changes only in the cycle after a read strobe and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W (8) | Byte offset of the access |
| wr_en | input | 1 | Write strobe |
| wdata | input | DW (32) | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DW (32) | Registered read data, valid the cycle after `rd_en` |

## Verification
The bench uses the default parameters: a 32-bit word, an 8-bit offset, a 12-bit sample accumulator, a step of 7 and 12-bit offsets. With these values the 6-bit resolution wraps after ten armed reads, so accumulator overflow and re-masking after a resolution change can be reached in a few hundred cycles. The 8-bit offset also covers the whole unmapped region up to 0xFC, and misaligned offsets next to live words.

// File: rtl/adc_rf_pkg.sv
package adc_rf_pkg;
   // word indices (byte offset / 4)
   localparam int unsigned IDX_SR    = 0;
   localparam int unsigned IDX_CR1   = 1;
   localparam int unsigned IDX_CR2   = 2;
   localparam int unsigned IDX_SMP_A = 3;
   localparam int unsigned IDX_SMP_B = 4;
   localparam int unsigned IDX_OFS0  = 5;
   localparam int unsigned IDX_HTHR  = 9;
   localparam int unsigned IDX_LTHR  = 10;
   localparam int unsigned IDX_SEQ0  = 11;
   localparam int unsigned IDX_ISEQ  = 14;
   localparam int unsigned IDX_IDAT0 = 15;
   localparam int unsigned IDX_DATA  = 19;

   localparam int unsigned INJ_LANES = 4;
   localparam int unsigned N_PLAIN   = 9;
   localparam int unsigned HTHR_SLOT = 3;
   localparam int unsigned SR_W      = 6;
   localparam int unsigned CR2_VIS   = 28;

   localparam int unsigned EN_BIT    = 0;
   localparam int unsigned ALIGN_BIT = 11;
   localparam int unsigned START_BIT = 30;
   localparam int unsigned RES_LSB   = 24;

   // plain read/write slot -> word index
   function automatic int unsigned plain_word(int unsigned slot);
      case (slot)
         0: return IDX_CR1;
         1: return IDX_SMP_A;
         2: return IDX_SMP_B;
         3: return IDX_HTHR;
         4: return IDX_LTHR;
         5: return IDX_SEQ0;
         6: return IDX_SEQ0 + 1;
         7: return IDX_SEQ0 + 2;
         default: return IDX_ISEQ;
      endcase
   endfunction
endpackage

// File: rtl/adc_rf_word_bank.sv
module adc_rf_word_bank #(
   parameter int unsigned DW  = 32,
   parameter int unsigned NUM = 4,
   parameter logic [NUM*DW-1:0] RST = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM-1:0]    we,
   input  logic [DW-1:0]     wdata,
   output logic [NUM*DW-1:0] q
);
   if (NUM < 1) begin : g_bad_num
      $fatal(1, "word bank needs at least one word");
   end

   for (genvar g = 0; g < NUM; g++) begin : g_word
      logic [DW-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     r <= RST[g*DW +: DW];
         else if (we[g]) r <= wdata;
      end
      assign q[g*DW +: DW] = r;
   end
endmodule

// File: rtl/adc_rf_inj_lane.sv
module adc_rf_inj_lane #(
   parameter int unsigned DW    = 32,
   parameter int unsigned OFS_W = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ofs_we,
   input  logic          dat_we,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] ofs_out,
   output logic [DW-1:0] diff_out
);
   if (OFS_W > DW || OFS_W < 1) begin : g_bad_ofs
      $fatal(1, "offset width must lie in 1..DW");
   end

   logic [OFS_W-1:0] ofs_q;
   logic [DW-1:0]    dat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ofs_q <= '0;
         dat_q <= '0;
      end else begin
         if (ofs_we) ofs_q <= wdata[OFS_W-1:0];
         if (dat_we) dat_q <= wdata;
      end
   end

   assign ofs_out  = DW'(ofs_q);
   assign diff_out = dat_q - DW'(ofs_q);
endmodule

// File: rtl/adc_rf_sample_gen.sv
module adc_rf_sample_gen #(
   parameter int unsigned DW   = 32,
   parameter int unsigned SW   = 12,
   parameter int unsigned STEP = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fire,
   input  logic [1:0]    res_code,
   input  logic          align,
   output logic [DW-1:0] sample
);
   localparam logic [DW-1:0] KEEP = DW'(((64'd1 << (SW + 4)) - 64'd1) & ~64'hF);

   if (SW < 8 || SW + 4 > DW) begin : g_bad_sw
      $fatal(1, "sample width must be at least 8 and leave room to align");
   end

   logic [SW-1:0] acc_q, stepped, mask, masked;
   logic [DW-1:0] wide;

   always_comb begin
      case (res_code)
         2'd0:    mask = {SW{1'b1}};
         2'd1:    mask = {SW{1'b1}} >> 2;
         2'd2:    mask = {SW{1'b1}} >> 4;
         default: mask = {SW{1'b1}} >> 6;
      endcase
      stepped = acc_q + SW'(STEP);
      masked  = stepped & mask;
      wide    = DW'(masked) << 1;
      sample  = align ? (wide & KEEP) : DW'(masked);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    acc_q <= '0;
      else if (fire) acc_q <= masked;
   end
endmodule

// File: rtl/adc_rf_synth.sv
module adc_rf_synth
   import adc_rf_pkg::*;
#(
   parameter int unsigned DW       = 32,
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned SAMPLE_W = 12,
   parameter int unsigned STEP     = 7,
   parameter int unsigned OFS_W    = 12,
   parameter logic [31:0] HTHR_RST = 32'h0000_0FFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [DW-1:0]     wdata,
   input  logic              rd_en,
   output logic [DW-1:0]     rd_data
);
   localparam int unsigned IDX_W = ADDR_W - 2;
   localparam logic [N_PLAIN*DW-1:0] PLAIN_RST =
      {{((N_PLAIN-1)*DW){1'b0}}, DW'(HTHR_RST)} << (HTHR_SLOT * DW);
   localparam logic [DW-1:0] CR2_MASK = DW'((64'd1 << CR2_VIS) - 64'd1);

   if (DW < 32) begin : g_bad_dw
      $fatal(1, "data width must be at least 32");
   end
   if (ADDR_W < 7) begin : g_bad_aw
      $fatal(1, "address must reach offset 0x4C");
   end

   // decode
   logic [IDX_W-1:0] widx;
   logic             mapped;
   assign widx   = addr[ADDR_W-1:2];
   assign mapped = (addr[1:0] == 2'b00) && (32'(widx) <= IDX_DATA);

   function automatic logic at(int unsigned k);
      return mapped && (32'(widx) == k);
   endfunction

   // control B and status
   logic [DW-1:0]   cr2_q;
   logic [SR_W-1:0] sr_q;
   logic            armed, fire;

   assign armed = cr2_q[EN_BIT] && cr2_q[START_BIT];
   assign fire  = rd_en && at(IDX_DATA) && armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cr2_q <= '0;
         sr_q  <= '0;
      end else begin
         if (wr_en && at(IDX_CR2)) cr2_q <= wdata;
         else if (fire)            cr2_q[START_BIT] <= 1'b0;
         if (wr_en && at(IDX_SR))  sr_q <= sr_q & wdata[SR_W-1:0];
      end
   end

   // plain words
   logic [N_PLAIN-1:0]    plain_we;
   logic [N_PLAIN*DW-1:0] plain_q;

   for (genvar g = 0; g < N_PLAIN; g++) begin : g_plain_sel
      assign plain_we[g] = wr_en && at(plain_word(g));
   end

   adc_rf_word_bank #(.DW(DW), .NUM(N_PLAIN), .RST(PLAIN_RST)) u_bank (
      .clk(clk), .rst_n(rst_n), .we(plain_we), .wdata(wdata), .q(plain_q)
   );

   // injected lanes
   logic [DW-1:0] ofs_rd  [INJ_LANES];
   logic [DW-1:0] diff_rd [INJ_LANES];

   for (genvar n = 0; n < INJ_LANES; n++) begin : g_lane
      adc_rf_inj_lane #(.DW(DW), .OFS_W(OFS_W)) u_lane (
         .clk(clk), .rst_n(rst_n),
         .ofs_we(wr_en && at(IDX_OFS0 + n)),
         .dat_we(wr_en && at(IDX_IDAT0 + n)),
         .wdata(wdata),
         .ofs_out(ofs_rd[n]),
         .diff_out(diff_rd[n])
      );
   end

   // synthetic sample
   logic [DW-1:0] sample;

   adc_rf_sample_gen #(.DW(DW), .SW(SAMPLE_W), .STEP(STEP)) u_gen (
      .clk(clk), .rst_n(rst_n), .fire(fire),
      .res_code(plain_q[RES_LSB +: 2]),
      .align(cr2_q[ALIGN_BIT]),
      .sample(sample)
   );

   // read path
   logic [DW-1:0] rd_next;

   always_comb begin
      rd_next = '0;
      if (at(IDX_SR))   rd_next = DW'(sr_q);
      if (at(IDX_CR2))  rd_next = cr2_q & CR2_MASK;
      if (at(IDX_DATA)) rd_next = armed ? sample : '0;
      for (int k = 0; k < N_PLAIN; k++)
         if (at(plain_word(k))) rd_next = plain_q[k*DW +: DW];
      for (int n = 0; n < INJ_LANES; n++) begin
         if (at(IDX_OFS0 + n))  rd_next = ofs_rd[n];
         if (at(IDX_IDAT0 + n)) rd_next = diff_rd[n];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= rd_next;
   end
endmodule

// File: rtl/adc_rf_checker.sv
module adc_rf_checker #(
   parameter int unsigned DW     = 32,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned OFS_W  = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              wr_en,
   input logic              rd_en,
   input logic [DW-1:0]     rd_data,
   input logic [DW-1:0]     cr2_q
);
   logic rd_sr, rd_cr2, rd_dat, rd_ofs, rd_bad, armed, wr_cr2;
   assign rd_sr  = rd_en && (addr == ADDR_W'(8'h00));
   assign rd_cr2 = rd_en && (addr == ADDR_W'(8'h08));
   assign rd_dat = rd_en && (addr == ADDR_W'(8'h4C));
   assign rd_ofs = rd_en && (addr[1:0] == 2'b00) &&
                   (addr >= ADDR_W'(8'h14)) && (addr <= ADDR_W'(8'h20));
   assign rd_bad = rd_en && ((addr[1:0] != 2'b00) || (addr > ADDR_W'(8'h4C)));
   assign armed  = cr2_q[0] && cr2_q[30];
   assign wr_cr2 = wr_en && (addr == ADDR_W'(8'h08));

   // R2: status upper bits read zero
   a_r2_status_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rd_sr |=> rd_data[DW-1:6] == '0);

   // R4: control B top nibble hidden
   a_r4_cr2_top_hidden: assert property (@(posedge clk) disable iff (!rst_n)
      rd_cr2 |=> rd_data[DW-1:28] == '0);

   // R5: offsets hold only OFS_W bits
   a_r5_offset_narrow: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ofs |=> (rd_data >> OFS_W) == '0);

   // R7: armed read consumes the start request
   a_r7_start_consumed: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_dat && armed && !wr_cr2) |=> !cr2_q[30]);

   // R10: unarmed data read returns zero and keeps control B
   a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_dat && !armed) |=> rd_data == '0);
   a_r10_idle_cr2_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_dat && !armed && !wr_en) |=> $stable(cr2_q));

   // R11: unmapped reads return zero
   a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rd_bad |=> rd_data == '0);

   // R12: read data holds without a strobe
   a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));
endmodule

bind adc_rf_synth adc_rf_checker #(.DW(DW), .ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
   .rd_en(rd_en), .rd_data(rd_data), .cr2_q(cr2_q)
);

// File: tb/adc_rf_synth_tb.sv
`timescale 1ns/1ps
module adc_rf_synth_tb;
   localparam logic [7:0] A_SR = 8'h00, A_CA = 8'h04, A_CB = 8'h08, A_SM0 = 8'h0C,
      A_SM1 = 8'h10, A_OF0 = 8'h14, A_HT = 8'h24, A_LT = 8'h28, A_SQ0 = 8'h2C,
      A_ISQ = 8'h38, A_ID0 = 8'h3C, A_DAT = 8'h4C;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic [7:0]  addr = '0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rd_data;

   int n_chk = 0, n_fail = 0;
   bit done = 0;
   int unsigned model_smp = 0;
   int unsigned model_res = 0;

   always #4 clk = ~clk;

   adc_rf_synth u_dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
      .wdata(wdata), .rd_en(rd_en), .rd_data(rd_data));

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
      if (a == A_CA) model_res = (d >> 24) & 3;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk); addr = a; rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0; d = rd_data;
   endtask

   function automatic int unsigned res_mask(int unsigned c);
      case (c) 0: return 32'hFFF; 1: return 32'h3FF; 2: return 32'hFF; default: return 32'h3F; endcase
   endfunction

   task automatic conv(input bit al, input string tag);
      logic [31:0] d;
      wr(A_CB, 32'h4000_0001 | (al ? 32'h800 : 32'h0));
      model_smp = (model_smp + 7) & res_mask(model_res);
      rd(A_DAT, d);
      check(tag, d, al ? ((model_smp << 1) & 32'hFFF0) : model_smp);
   endtask

   task automatic t_reset;
      logic [31:0] d;
      for (int a = 0; a <= 'h4C; a += 4) begin
         rd(8'(a), d);
         check($sformatf("R1 reset word 0x%02h", a), d, (a == 'h24) ? 32'hFFF : 32'h0);
      end
   endtask

   task automatic t_plain;
      logic [31:0] d;
      logic [7:0] list [9] = '{A_CA, A_SM0, A_SM1, A_HT, A_LT, A_SQ0, 8'h30, 8'h34, A_ISQ};
      for (int i = 0; i < 9; i++) wr(list[i], 32'hA5C3_0000 ^ (32'h1111 * (i + 1)) ^ 32'h00FC_0000);
      for (int i = 0; i < 9; i++) begin
         rd(list[i], d);
         check("R3 plain readback", d, 32'hA5C3_0000 ^ (32'h1111 * (i + 1)) ^ 32'h00FC_0000);
      end
      wr(A_CA, 32'h0);
   endtask

   task automatic t_status;
      logic [31:0] d;
      wr(A_SR, 32'hFFFF_FFFF); rd(A_SR, d); check("R2 status stays clear", d, 32'h0);
      wr(A_SR, 32'h0000_003F); rd(A_SR, d); check("R2 status and-write", d, 32'h0);
   endtask

   task automatic t_cr2;
      logic [31:0] d;
      wr(A_CB, 32'hFFFF_FFFF); rd(A_CB, d); check("R4 cr2 top masked", d, 32'h0FFF_FFFF);
      wr(A_CB, 32'h4000_0001); rd(A_CB, d); check("R4 start bit hidden", d, 32'h1);
      model_smp = (model_smp + 7) & res_mask(model_res);
      rd(A_DAT, d); check("R7 armed read by hidden bit", d, model_smp);
      rd(A_CB, d); check("R7 cr2 after consume", d, 32'h1);
      rd(A_DAT, d); check("R7 start consumed, second read", d, 32'h0);
   endtask

   task automatic t_inj;
      logic [31:0] d;
      for (int n = 0; n < 4; n++) begin
         wr(8'(A_OF0 + 4 * n), 32'hABCD_E120 + n);
         wr(8'(A_ID0 + 4 * n), 32'h0001_0000 * (n + 1));
      end
      for (int n = 0; n < 4; n++) begin
         rd(8'(A_OF0 + 4 * n), d); check("R5 offset 12 bits", d, 32'h120 + n);
         rd(8'(A_ID0 + 4 * n), d);
         check("R6 data minus offset", d, 32'h0001_0000 * (n + 1) - (32'h120 + n));
      end
      wr(8'(A_ID0 + 8), 32'h5); wr(8'(A_OF0 + 8), 32'h10);
      rd(8'(A_ID0 + 8), d); check("R6 wraparound", d, 32'hFFFF_FFF5);
   endtask

   task automatic t_res;
      for (int c = 3; c >= 0; c--) begin
         wr(A_CA, 32'(c) << 24);
         for (int i = 0; i < 12; i++) conv(1'b0, $sformatf("R8 resolution code %0d", c));
      end
   endtask

   task automatic t_align;
      wr(A_CA, 32'h0);
      for (int i = 0; i < 4; i++) conv(1'b1, "R9 left aligned");
      wr(A_CA, 32'h0200_0000);
      conv(1'b1, "R9 aligned at 8 bit");
      wr(A_CA, 32'h0);
   endtask

   task automatic t_idle;
      logic [31:0] d;
      wr(A_CB, 32'h0000_0801); rd(A_DAT, d); check("R10 enable only", d, 32'h0);
      rd(A_CB, d); check("R10 cr2 kept", d, 32'h801);
      wr(A_CB, 32'h4000_0000); rd(A_DAT, d); check("R10 start only", d, 32'h0);
      conv(1'b0, "R10 sample not advanced by idle reads");
   endtask

   task automatic t_unmapped;
      logic [31:0] d;
      wr(A_CA, 32'h0000_1234); wr(A_LT, 32'h0000_0055);
      wr(8'h06, 32'hFFFF_FFFF); wr(8'h50, 32'hFFFF_FFFF); wr(8'hFC, 32'hFFFF_FFFF);
      wr(8'h29, 32'hFFFF_FFFF);
      rd(8'h50, d); check("R11 read 0x50", d, 32'h0);
      rd(8'hFC, d); check("R11 read 0xFC", d, 32'h0);
      rd(8'h05, d); check("R11 misaligned read", d, 32'h0);
      rd(A_CA, d);  check("R11 control A untouched", d, 32'h0000_1234);
      rd(A_LT, d);  check("R11 low threshold untouched", d, 32'h0000_0055);
      wr(A_CA, 32'h0);
   endtask

   task automatic t_hold;
      logic [31:0] d;
      wr(A_HT, 32'h0000_0ABC);
      rd(A_HT, d);
      @(negedge clk); addr = A_LT; wdata = 32'h77;
      repeat (3) @(negedge clk);
      check("R12 hold without strobe", rd_data, 32'h0000_0ABC);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 rd_data in reset", rd_data, 32'h0);
      rst_n = 1'b1;
      t_reset();
      t_plain();
      t_status();
      t_cr2();
      t_inj();
      t_res();
      t_align();
      t_idle();
      t_unmapped();
      t_hold();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule